// File: doc/BRIEF.md
# FIFO Threshold Interrupt Unit

This block holds the transmit and receive byte queues that sit between software and a serial bus engine. Software fills the transmit queue and drains the receive queue through a small word-addressed register port. The bus engine pops transmit bytes and pushes received bytes through a plain byte interface. Each queue reports its fill level, full and empty, and compares its level against a programmable trigger. Software therefore services the queues in bursts instead of byte by byte.

Seven conditions feed a sticky interrupt status register, which is cleared by writing ones:
- transmit almost-empty and receive almost-full, derived from the triggers;
- underrun and overrun on each queue;
- a trailing-data condition. It flags a short remainder of received bytes, below the receive trigger, that has sat idle for a programmed number of cycles.

A per-bit enable mask selects which status bits drive the single interrupt line. The serial protocol itself lies outside this block.

Top module: `fifo_thresh_irq`

Register map (word address on `reg_addr`): 0 control, 1 trailing idle limit (bits 3:0), 2 interrupt enable (bits 6:0), 3 interrupt status, 4 queue status (read only), 5 data (a write pushes a transmit byte, a read pops a receive byte).

## Requirements
- R1: After reset both queues are empty, so the queue status reads 0x0100_0100. Control, enable and status all read zero and `irq` is low.
- R2: Control bit 0 enables the receive queue and bit 1 enables the transmit queue. Bits 10:4 hold the receive trigger and bits 22:16 hold the transmit trigger. A disabled queue is flushed to empty, and bytes offered to it are dropped without any flag.
- R3: Writes to the data address enter the transmit queue, and `tx_pop` returns the bytes in write order on `tx_data`. The queue status shows the transmit level in bits 6:0, full in bit 7 and empty in bit 8.
- R4: `rx_push` bytes are returned in arrival order by reads of the data address. The queue status shows the receive level in bits 22:16, full in bit 23 and empty in bit 24.
- R5: Status bit 0 (transmit almost-empty) is set while the transmit queue is enabled and its level is at or below the transmit trigger. It appears one cycle after the level changes.
- R6: Status bit 1 (receive almost-full) is set while the receive queue is enabled and its level is at or above the receive trigger. It appears one cycle after the level changes.
- R7: A transmit pop from an empty queue returns zero and sets status bit 2. A data write to a full transmit queue drops the byte and sets status bit 3.
- R8: A receive data read from an empty queue returns zero and sets status bit 4. A push to a full receive queue drops the byte and sets status bit 5.
- R9: Status bit 6 (trailing) is set when the receive queue holds at least one byte but fewer than the trigger, and no push has arrived for the programmed idle limit in cycles. It is never set while the level is at or above the trigger.
- R10: Status bits are sticky. Writing a one to a status bit clears it only if its cause is no longer present, and writing zeros changes nothing.
- R11: `irq` is high exactly when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 5) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 23 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| tx_pop | input | 1 | Bus engine takes the head transmit byte |
| tx_data | output | 8 | Head transmit byte, zero when empty |
| rx_push | input | 1 | Bus engine delivers a received byte |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |

## Verification
Queue levels, full and empty change at the clock edge that samples a push, pop or data access. Read data and `tx_data` are combinational, so they are sampled shortly after the strobe is driven, before that edge consumes the byte. Threshold and trailing bits are registered from the level one edge later, while error bits are set at the same edge as the offending access. Status is therefore read at least one full cycle after the stimulus. For the trailing flag, the bench counts falling edges after the last push and expects `irq` low after exactly the idle limit and high one cycle later.

// File: rtl/fifo_thresh_irq.sv
module fifo_thresh_irq #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [22:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_pop,
  output logic [7:0]  tx_data,
  input  logic        rx_push,
  input  logic [7:0]  rx_data,
  output logic        irq
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [2:0] A_CTL = 3'd0, A_TRAIL = 3'd1, A_IEN = 3'd2,
                         A_ISTAT = 3'd3, A_FSTAT = 3'd4, A_DATA = 3'd5;

  logic [22:0] ctl_q;
  logic [3:0]  trail_lim;
  logic [6:0]  ien, stat;
  logic        rx_en, tx_en;
  logic [6:0]  rx_trig, tx_trig;

  assign rx_en   = ctl_q[0];
  assign tx_en   = ctl_q[1];
  assign rx_trig = ctl_q[10:4];
  assign tx_trig = ctl_q[22:16];

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [3:0]    idle;

  logic wr_data, rd_data;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_do_wr, tx_do_rd, rx_do_wr, rx_do_rd;
  logic [6:0] tx_lvl, rx_lvl;

  assign wr_data  = reg_wr && reg_addr == A_DATA;
  assign rd_data  = reg_rd && reg_addr == A_DATA;
  assign tx_full  = tx_cnt == CW'(DEPTH);
  assign tx_empty = tx_cnt == '0;
  assign rx_full  = rx_cnt == CW'(DEPTH);
  assign rx_empty = rx_cnt == '0;
  assign tx_do_wr = tx_en && wr_data && !tx_full;
  assign tx_do_rd = tx_pop && !tx_empty;
  assign rx_do_wr = rx_en && rx_push && !rx_full;
  assign rx_do_rd = rd_data && !rx_empty;
  assign tx_lvl   = 7'(tx_cnt);
  assign rx_lvl   = 7'(rx_cnt);
  assign tx_data  = tx_empty ? 8'h00 : tx_mem[tx_rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      trail_lim <= '0;
      ien       <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTL)   ctl_q     <= reg_wdata;
      if (reg_addr == A_TRAIL) trail_lim <= reg_wdata[3:0];
      if (reg_addr == A_IEN)   ien       <= reg_wdata[6:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (!tx_en) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_do_wr) tx_wp <= tx_wp + PW'(1);
      if (tx_do_rd) tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + CW'(tx_do_wr) - CW'(tx_do_rd);
    end
  end

  always_ff @(posedge clk) if (tx_do_wr) tx_mem[tx_wp] <= reg_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (!rx_en) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_do_wr) rx_wp <= rx_wp + PW'(1);
      if (rx_do_rd) rx_rp <= rx_rp + PW'(1);
      rx_cnt <= rx_cnt + CW'(rx_do_wr) - CW'(rx_do_rd);
    end
  end

  always_ff @(posedge clk) if (rx_do_wr) rx_mem[rx_wp] <= rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          idle <= '0;
    else if (!rx_en || rx_empty || rx_do_wr) idle <= '0;
    else if (idle != 4'hF)               idle <= idle + 4'd1;
  end

  logic [6:0] set_v, clr_v;
  assign set_v = {
    rx_en && !rx_empty && rx_lvl < rx_trig && idle >= trail_lim,
    rx_en && rx_push && rx_full,
    rd_data && rx_empty,
    tx_en && wr_data && tx_full,
    tx_pop && tx_empty,
    rx_en && rx_lvl >= rx_trig,
    tx_en && tx_lvl <= tx_trig
  };
  assign clr_v = (reg_wr && reg_addr == A_ISTAT) ? reg_wdata[6:0] : 7'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_v) | set_v;
  end

  assign irq = |(stat & ien);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL:   reg_rdata = {9'd0, ctl_q};
      A_TRAIL: reg_rdata = {28'd0, trail_lim};
      A_IEN:   reg_rdata = {25'd0, ien};
      A_ISTAT: reg_rdata = {25'd0, stat};
      A_FSTAT: reg_rdata = {7'd0, rx_empty, rx_full, rx_lvl,
                            7'd0, tx_empty, tx_full, tx_lvl};
      A_DATA:  reg_rdata = {24'd0, rx_empty ? 8'h00 : rx_mem[rx_rp]};
      default: reg_rdata = '0;
    endcase
  end

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));

  a_r2_disabled_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_cnt == '0);

  a_r8_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_en && rx_full && !rd_data && !(reg_wr && reg_addr == A_CTL))
    |=> (stat[5] && rx_cnt == CW'(DEPTH)));

  a_r9_trail_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[6]) |-> $past(rx_cnt) != '0);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[2] && !(reg_wr && reg_addr == A_ISTAT && reg_wdata[2])) |=> stat[2]);

endmodule

// File: tb/test_fifo_thresh_irq.sv
module test_fifo_thresh_irq;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [22:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic tx_pop = 0, rx_push = 0;
  logic [7:0] tx_data, rx_data = 0;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  fifo_thresh_irq i_fifo_thresh_irq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_data(tx_data), .rx_push(rx_push),
    .rx_data(rx_data), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [22:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_data = b;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic pop(output logic [7:0] b);
    @(negedge clk); tx_pop = 1;
    #1 b = tx_data;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd4, d); check("R1 queue status", d, 32'h0100_0100);
    rd(3'd0, d); check("R1 control", d, 0);
    rd(3'd3, d); check("R1 int status", d, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    push(8'h55);
    rd(3'd4, d); check("R2 disabled rx stays empty", d, 32'h0100_0100);
    rd(3'd3, d); check("R2 no flag when disabled", d, 0);
    wr(3'd1, 23'd15);
    wr(3'd0, 23'h02_0043);
    rd(3'd0, d); check("R2 control readback", d, 32'h0002_0043);
    rd(3'd3, d); check("R5 tx almost-empty at level 0", d, 32'h1);
    wr(3'd2, 23'h01);
    check("R11 irq enabled", {31'd0, irq}, 1);
    wr(3'd3, 23'h01);
    rd(3'd3, d); check("R10 clear ignored while cause holds", d, 32'h1);
    wr(3'd2, 23'h00);
    check("R11 irq masked", {31'd0, irq}, 0);
  endtask

  task automatic t_tx;
    logic [31:0] d; logic [7:0] b;
    wr(3'd5, 23'hA1); wr(3'd5, 23'hA2); wr(3'd5, 23'hA3);
    rd(3'd4, d); check("R3 tx level 3", d & 32'h1FF, 32'h003);
    wr(3'd3, 23'h7F);
    rd(3'd3, d); check("R5 above trigger, cleared", d, 0);
    pop(b); check("R3 order 1", {24'd0, b}, 32'hA1);
    pop(b); check("R3 order 2", {24'd0, b}, 32'hA2);
    pop(b); check("R3 order 3", {24'd0, b}, 32'hA3);
    rd(3'd3, d); check("R5 almost-empty returns", d, 32'h1);
  endtask

  task automatic t_tx_full;
    logic [31:0] d; logic [7:0] b;
    for (int i = 0; i < 16; i++) wr(3'd5, 23'(8'h10 + i));
    rd(3'd4, d); check("R3 tx full level 16", d & 32'h1FF, 32'h090);
    wr(3'd5, 23'hEE);
    rd(3'd3, d); check("R7 tx overrun", d & 32'h8, 32'h8);
    rd(3'd4, d); check("R7 level unchanged", d & 32'h1FF, 32'h090);
    for (int i = 0; i < 16; i++) begin
      pop(b); check("R7 byte kept, overrun dropped", {24'd0, b}, 32'(8'h10 + i));
    end
    pop(b); check("R7 empty pop zero", {24'd0, b}, 0);
    rd(3'd3, d); check("R7 tx underrun", d & 32'h4, 32'h4);
    rd(3'd4, d); check("R3 tx empty", d & 32'h1FF, 32'h100);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    wr(3'd3, 23'h7F);
    push(8'h30); push(8'h31); push(8'h32);
    rd(3'd4, d); check("R4 rx level 3", (d >> 16) & 32'h1FF, 32'h003);
    rd(3'd3, d); check("R6 below trigger", d & 32'h2, 0);
    push(8'h33);
    rd(3'd3, d); check("R6 almost-full at trigger", d & 32'h2, 32'h2);
    for (int i = 0; i < 4; i++) begin
      rd(3'd5, d); check("R4 rx order", d, 32'(8'h30 + i));
    end
  endtask

  task automatic t_rx_full;
    logic [31:0] d;
    wr(3'd3, 23'h7F);
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i));
    rd(3'd4, d); check("R4 rx full level 16", (d >> 16) & 32'h1FF, 32'h090);
    push(8'hEE);
    rd(3'd3, d); check("R8 rx overrun", d & 32'h20, 32'h20);
    for (int i = 0; i < 16; i++) begin
      rd(3'd5, d); check("R8 byte kept, overrun dropped", d, 32'(8'h40 + i));
    end
    rd(3'd5, d); check("R8 empty read zero", d, 0);
    rd(3'd3, d); check("R8 rx underrun", d & 32'h10, 32'h10);
  endtask

  task automatic t_trail;
    logic [31:0] d;
    wr(3'd1, 23'd5);
    wr(3'd2, 23'h40);
    wr(3'd3, 23'h7F);
    check("R9 no trail when empty", {31'd0, irq}, 0);
    push(8'h61); push(8'h62);
    repeat (5) @(negedge clk);
    check("R9 not yet at idle limit", {31'd0, irq}, 0);
    @(negedge clk);
    check("R9 trail after idle limit", {31'd0, irq}, 1);
    rd(3'd3, d); check("R9 status bit 6", d & 32'h40, 32'h40);
    push(8'h63); push(8'h64);
    wr(3'd3, 23'h40);
    repeat (10) @(negedge clk);
    check("R9 none at or above trigger", {31'd0, irq}, 0);
    for (int i = 0; i < 4; i++) begin
      rd(3'd5, d); check("R4 rx order after trail", d, 32'(8'h61 + i));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_enable;
    t_tx;
    t_tx_full;
    t_rx;
    t_rx_full;
    t_trail;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule